// File: doc/BRIEF.md
# Two-Wire Bus Master with Byte Holding Registers

This block is the single master of a two-wire serial bus (SCL clock, SDA data, both open-drain). Software configures a 7-bit target address, a direction bit and an optional one-byte register index. It then pulses a start command. The block produces the start condition and shifts out the address byte. From there it moves data one byte at a time through two holding registers: an outgoing byte register that software refills, and an incoming byte register that software drains.

Readiness of both registers, completion of the whole transfer and a missing acknowledge from the target are reported as level flags. In write direction the controller ends the transfer on its own when a byte has been acknowledged and no further byte is waiting. In read direction software asks for the end with a stop command before the final byte arrives. The block then withholds the acknowledge on that byte and closes the bus. SCL timing comes from the system clock through separately programmable low and high counts.

Top module: `i2c_hold_master`

## Requirements
- R1: After reset, sts_txcomp=1, sts_txrdy=1, sts_rxrdy=0, sts_nack=0, and neither scl_oe nor sda_oe pulls its line.
- R2: A cmd_start pulse while idle produces a start condition, which is SDA pulled low while SCL is released. The first byte sent is {cfg_dev_addr, cfg_read}, MSB first, with direction bit 1 meaning read. sts_txcomp is 0 from the cycle after the accepted pulse.
- R3: On the 9th clock of every transmitted byte, the block releases SDA and samples it at the end of the SCL high phase. A high sample sets sts_nack. The flag stays set until a sts_rd pulse clears it. If both happen in one cycle, the set wins.
- R4: In read direction, each received byte is loaded into rhr_data and sets sts_rxrdy. rhr_rd clears sts_rxrdy. The master pulls SDA low on the 9th clock of every received byte except the last.
- R5: thr_wr stores thr_data and drops sts_txrdy on the next cycle. The engine takes the stored byte when a data byte begins, which raises sts_txrdy again.
- R6: In write direction, if a byte is acknowledged and no byte is held (sts_txrdy=1), a stop condition follows. This includes a transfer that carries no data byte at all.
- R7: With cfg_iaddr_en=1 in write direction, cfg_iaddr is sent after the address byte's acknowledge and before the first data byte.
- R8: sts_txcomp rises only after the stop condition has completed (SDA released while SCL is high). While sts_txcomp=1, both lines are released.
- R9: A cmd_stop pulse given before the 9th clock of a received byte makes that byte the last one: it is not acknowledged and a stop follows. cmd_stop together with cmd_start gives a one-byte read.
- R10: A missing acknowledge abandons the transfer. A stop is sent, sts_txcomp rises, and any byte still held is not sent.
- R11: Each SCL low phase lasts cfg_scl_lo cycles and each high phase cfg_scl_hi cycles (both must be at least 3). SDA changes while SCL is released only to form a start or stop condition.
- R12: cmd_start while a transfer is in progress is ignored: no second start condition appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start-transfer pulse |
| cmd_stop | input | 1 | Request to end a read after the next received byte |
| cfg_read | input | 1 | Direction: 1 read, 0 write |
| cfg_dev_addr | input | 7 | Target device address |
| cfg_iaddr_en | input | 1 | Send one register-index byte in writes |
| cfg_iaddr | input | 8 | Register-index byte |
| cfg_scl_lo | input | DIV_W | SCL low phase length in clocks |
| cfg_scl_hi | input | DIV_W | SCL high phase length in clocks |
| thr_wr | input | 1 | Write strobe for the outgoing byte register |
| thr_data | input | 8 | Byte to send |
| sts_txrdy | output | 1 | Outgoing byte register empty |
| rhr_rd | input | 1 | Read strobe for the incoming byte register |
| rhr_data | output | 8 | Last received byte |
| sts_rxrdy | output | 1 | Incoming byte register holds an unread byte |
| sts_txcomp | output | 1 | No transfer in progress |
| sts_nack | output | 1 | Target failed to acknowledge |
| sts_rd | input | 1 | Status read strobe, clears sts_nack |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The checker assumes that cfg_scl_lo and cfg_scl_hi are at least 3 and are held steady during a transfer. It also assumes that the configuration fields do not change between cmd_start and the rise of sts_txcomp. The bench sets both counts once (5 low, 4 high) and changes the configuration only while idle. The SDA rule assumes that SCL is never held low by a target. The bench target model therefore drives only SDA, and changes it only just after it sees SCL fall.

// File: rtl/i2chm_pkg.sv
package i2chm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_BLO,
        PH_BHI,
        PH_PLO,
        PH_PHI,
        PH_PEND
    } phase_t;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_IADR,
        BK_WR,
        BK_RD
    } bkind_t;

    typedef struct packed {
        phase_t     ph;
        bkind_t     kind;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       drv;
        logic       rd;
        logic       last;
        logic       stop_req;
        logic [7:0] thr;
        logic       thr_full;
        logic [7:0] rhr;
        logic       rxrdy;
        logic       nack;
        logic       txcomp;
        logic       scl_oe;
        logic       sda_oe;
    } eng_t;

endpackage

// File: rtl/i2chm_sync.sv
module i2chm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_q, ff_d;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/i2chm_timer.sv
module i2chm_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] period,
    output logic         done
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)            cnt_d = period - 1'b1;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/i2c_hold_master.sv
module i2c_hold_master
    import i2chm_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cfg_read,
    input  logic [6:0]       cfg_dev_addr,
    input  logic             cfg_iaddr_en,
    input  logic [7:0]       cfg_iaddr,
    input  logic [DIV_W-1:0] cfg_scl_lo,
    input  logic [DIV_W-1:0] cfg_scl_hi,
    input  logic             thr_wr,
    input  logic [7:0]       thr_data,
    output logic             sts_txrdy,
    input  logic             rhr_rd,
    output logic [7:0]       rhr_data,
    output logic             sts_rxrdy,
    output logic             sts_txcomp,
    output logic             sts_nack,
    input  logic             sts_rd,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    eng_t q, d;
    logic sda_s;
    logic tmr_done;
    logic tmr_restart;
    logic [DIV_W-1:0] tmr_period;

    i2chm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sda_in),
        .dout (sda_s)
    );

    i2chm_timer #(.W(DIV_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tmr_restart),
        .period (tmr_period),
        .done   (tmr_done)
    );

    // Pull decision for one bit slot: data bits of outgoing bytes follow the
    // shift MSB, the 9th slot of an incoming byte carries the acknowledge.
    function automatic logic drive_for(bkind_t k, logic [3:0] b, logic [7:0] s, logic sr);
        if (b == 4'd8) return (k == BK_RD) ? ~sr : 1'b0;
        return (k == BK_RD) ? 1'b0 : ~s[7];
    endfunction

    always_comb begin
        d = q;
        if (cmd_stop) d.stop_req = 1'b1;
        if (sts_rd)   d.nack     = 1'b0;
        if (rhr_rd)   d.rxrdy    = 1'b0;

        case (q.ph)
            PH_IDLE: begin
                if (cmd_start) begin
                    d.ph       = PH_START;
                    d.txcomp   = 1'b0;
                    d.stop_req = cmd_stop;
                    d.kind     = BK_ADDR;
                    d.rd       = cfg_read;
                    d.sh       = {cfg_dev_addr, cfg_read};
                    d.bitn     = 4'd0;
                    d.last     = 1'b0;
                end
            end
            PH_START: begin
                if (tmr_done) begin
                    d.ph  = PH_BLO;
                    d.drv = drive_for(q.kind, q.bitn, q.sh, d.stop_req);
                end
            end
            PH_BLO: begin
                if (tmr_done) d.ph = PH_BHI;
            end
            PH_BHI: begin
                if (tmr_done) begin
                    if (q.bitn != 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bitn = q.bitn + 4'd1;
                        d.ph   = PH_BLO;
                        d.drv  = drive_for(q.kind, d.bitn, d.sh, d.stop_req);
                        if (d.bitn == 4'd8 && q.kind == BK_RD) d.last = d.stop_req;
                    end else begin
                        d.bitn = 4'd0;
                        if (q.kind == BK_RD) begin
                            d.rhr   = q.sh;
                            d.rxrdy = 1'b1;
                            if (q.last) begin
                                d.ph = PH_PLO;
                            end else begin
                                d.ph  = PH_BLO;
                                d.drv = 1'b0;
                            end
                        end else if (sda_s) begin
                            d.nack = 1'b1;
                            d.ph   = PH_PLO;
                        end else if (q.kind == BK_ADDR && q.rd) begin
                            d.kind = BK_RD;
                            d.ph   = PH_BLO;
                            d.drv  = 1'b0;
                        end else if (q.kind == BK_ADDR && cfg_iaddr_en) begin
                            d.kind = BK_IADR;
                            d.sh   = cfg_iaddr;
                            d.ph   = PH_BLO;
                            d.drv  = ~cfg_iaddr[7];
                        end else if (q.thr_full) begin
                            d.kind     = BK_WR;
                            d.sh       = q.thr;
                            d.thr_full = 1'b0;
                            d.ph       = PH_BLO;
                            d.drv      = ~q.thr[7];
                        end else begin
                            d.ph = PH_PLO;
                        end
                    end
                end
            end
            PH_PLO: begin
                if (tmr_done) d.ph = PH_PHI;
            end
            PH_PHI: begin
                if (tmr_done) d.ph = PH_PEND;
            end
            PH_PEND: begin
                if (tmr_done) begin
                    d.ph     = PH_IDLE;
                    d.txcomp = 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase

        if (thr_wr) begin
            d.thr      = thr_data;
            d.thr_full = 1'b1;
        end

        d.scl_oe = (d.ph == PH_BLO) || (d.ph == PH_PLO);
        // SDA follows the phase one cycle late, so it moves only after SCL fell.
        case (q.ph)
            PH_START, PH_PLO, PH_PHI: d.sda_oe = 1'b1;
            PH_BLO, PH_BHI:           d.sda_oe = q.drv;
            default:                  d.sda_oe = 1'b0;
        endcase
    end

    assign tmr_restart = (d.ph != q.ph);
    assign tmr_period  = ((d.ph == PH_BLO) || (d.ph == PH_PLO)) ? cfg_scl_lo : cfg_scl_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ph     <= PH_IDLE;
            q.kind   <= BK_ADDR;
            q.txcomp <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sts_txrdy  = ~q.thr_full;
    assign sts_rxrdy  = q.rxrdy;
    assign rhr_data   = q.rhr;
    assign sts_txcomp = q.txcomp;
    assign sts_nack   = q.nack;
    assign scl_oe     = q.scl_oe;
    assign sda_oe     = q.sda_oe;
endmodule

// File: rtl/i2chm_chk.sv
module i2chm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       sts_txcomp,
    input logic       sts_txrdy,
    input logic       sts_rxrdy,
    input logic       sts_nack,
    input logic       sts_rd,
    input logic       thr_wr,
    input logic [7:0] rhr_data
);
    assert_idle_lines_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sts_txcomp |-> (!scl_oe && !sda_oe));

    assert_rhr_moves_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rhr_data) |-> sts_rxrdy);

    assert_thr_write_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !sts_txrdy);

    assert_nack_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_nack && !sts_rd) |=> sts_nack);

    assert_sda_high_scl_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> !sts_txcomp);
endmodule

bind i2c_hold_master i2chm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sts_txcomp(sts_txcomp),
    .sts_txrdy (sts_txrdy),
    .sts_rxrdy (sts_rxrdy),
    .sts_nack  (sts_nack),
    .sts_rd    (sts_rd),
    .thr_wr    (thr_wr),
    .rhr_data  (rhr_data)
);

// File: tb/i2c_hold_master_test.sv
module i2c_hold_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int LO = 5;
    localparam int HI = 4;
    localparam logic [6:0] SLV = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_stop = 0, cfg_read = 0, cfg_iaddr_en = 0;
    logic [6:0] cfg_dev_addr = SLV;
    logic [7:0] cfg_iaddr = 8'h00;
    logic [DW-1:0] cfg_scl_lo = DW'(LO), cfg_scl_hi = DW'(HI);
    logic thr_wr = 0, rhr_rd = 0, sts_rd = 0;
    logic [7:0] thr_data = 8'h00;
    logic sts_txrdy, sts_rxrdy, sts_txcomp, sts_nack, scl_oe, sda_oe;
    logic [7:0] rhr_data;
    logic s_pull = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | s_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_hold_master #(.DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cfg_read(cfg_read), .cfg_dev_addr(cfg_dev_addr), .cfg_iaddr_en(cfg_iaddr_en),
        .cfg_iaddr(cfg_iaddr), .cfg_scl_lo(cfg_scl_lo), .cfg_scl_hi(cfg_scl_hi),
        .thr_wr(thr_wr), .thr_data(thr_data), .sts_txrdy(sts_txrdy), .rhr_rd(rhr_rd),
        .rhr_data(rhr_data), .sts_rxrdy(sts_rxrdy), .sts_txcomp(sts_txcomp),
        .sts_nack(sts_nack), .sts_rd(sts_rd), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_in(sda_line)
    );

    int vec = 0, bad = 0;
    bit finished = 0;
    string cur_req = "R2";
    logic [7:0] exp_wr[$];
    logic [7:0] exp_rd[$];
    logic [7:0] slv_tx[$];
    logic [7:0] wq[$];
    int starts = 0, stops = 0, macks = 0, mnacks = 0;
    int nack_at = -1;
    int lo_last = 0, hi_last = 0, run = 0;
    logic scl_oe_p = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Target model and scoreboard monitor for bytes seen on the bus.
    int bitc = 0, bidx = 0;
    bit active = 0, txm = 0, go_tx = 0, macked = 0;
    logic [7:0] rx = 0, txb = 0;
    logic scl_p = 1'b1, sda_p = 1'b1;

    always @(negedge clk) begin
        logic scl_n, sda_n, ack;
        logic [7:0] e;
        scl_n = scl_line;
        sda_n = sda_line;
        if (rst_n) begin
            if (scl_n && scl_p && sda_p && !sda_n) begin
                starts++; active = 1; bitc = 0; bidx = 0; txm = 0; go_tx = 0; s_pull = 0;
            end else if (scl_n && scl_p && !sda_p && sda_n) begin
                stops++; active = 0; txm = 0; s_pull = 0;
            end else if (active && scl_n && !scl_p) begin
                if (bitc < 8) begin
                    if (!txm) rx = {rx[6:0], sda_n};
                    bitc++;
                end else if (bitc == 8) begin
                    if (txm) begin
                        macked = !sda_n;
                        if (macked) macks++; else mnacks++;
                    end
                    bitc = 9;
                end
            end else if (active && !scl_n && scl_p) begin
                if (bitc == 8) begin
                    if (!txm) begin
                        if (exp_wr.size() == 0) begin
                            chk(0, cur_req, rx, 'hfff);
                        end else begin
                            e = exp_wr.pop_front();
                            chk(rx == e, cur_req, rx, e);
                        end
                        ack = (bidx != 0 || rx[7:1] == SLV) && (bidx != nack_at);
                        if (bidx == 0 && rx[0] && ack) go_tx = 1;
                        s_pull = ack;
                        bidx++;
                    end else begin
                        s_pull = 0;
                    end
                end else if (bitc == 9) begin
                    bitc = 0;
                    if (go_tx) begin go_tx = 0; txm = 1; macked = 1; end
                    if (txm && macked && slv_tx.size() > 0) begin
                        txb = slv_tx.pop_front();
                        s_pull = !txb[7];
                    end else begin
                        s_pull = 0;
                    end
                end else if (txm && bitc >= 1 && bitc <= 7) begin
                    s_pull = !txb[7-bitc];
                end
            end
        end
        scl_p = scl_n;
        sda_p = sda_n;
        // SCL phase length monitor (R11)
        if (scl_oe != scl_oe_p) begin
            if (scl_oe_p) lo_last = run; else hi_last = run;
            run = 1;
        end else begin
            run++;
        end
        scl_oe_p = scl_oe;
    end

    task automatic pulse_start(input bit with_stop);
        @(negedge clk); cmd_start = 1; cmd_stop = with_stop;
        @(negedge clk); cmd_start = 0; cmd_stop = 0;
    endtask

    task automatic load_thr(input logic [7:0] b);
        @(negedge clk); thr_wr = 1; thr_data = b;
        @(negedge clk); thr_wr = 0;
    endtask

    task automatic wait_idle();
        while (!sts_txcomp) @(negedge clk);
    endtask

    // Driver: pushes expected bus bytes, then runs a write transfer from wq.
    task automatic do_write(input logic [6:0] a, input bit ien, input logic [7:0] ia, input bit poke);
        cfg_read = 0; cfg_dev_addr = a; cfg_iaddr_en = ien; cfg_iaddr = ia;
        exp_wr.push_back({a, 1'b0});
        if (ien) exp_wr.push_back(ia);
        foreach (wq[i]) exp_wr.push_back(wq[i]);
        if (wq.size() > 0) begin
            load_thr(wq.pop_front());
            chk(sts_txrdy == 0, "R5", sts_txrdy, 0);
        end
        pulse_start(0);
        chk(sts_txcomp == 0, "R2", sts_txcomp, 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            pulse_start(0);
        end
        while (wq.size() > 0 && !sts_txcomp) begin
            if (sts_txrdy) load_thr(wq.pop_front());
            else @(negedge clk);
        end
        wait_idle();
    endtask

    task automatic do_read(input int n);
        cfg_read = 1; cfg_dev_addr = SLV; cfg_iaddr_en = 0;
        exp_wr.push_back({SLV, 1'b1});
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'(8'h3C + 8'(i * 8'h47));
            slv_tx.push_back(v);
            exp_rd.push_back(v);
        end
        pulse_start(n == 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            while (!sts_rxrdy) @(negedge clk);
            e = exp_rd.pop_front();
            chk(rhr_data == e, "R4", rhr_data, e);
            @(negedge clk); rhr_rd = 1;
            @(negedge clk); rhr_rd = 0;
            chk(sts_rxrdy == 0, "R4", sts_rxrdy, 0);
            if (i == n - 2) begin
                @(negedge clk); cmd_stop = 1;
                @(negedge clk); cmd_stop = 0;
            end
        end
        wait_idle();
        cfg_read = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vec++; bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        int s0, p0, a0, n0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sts_txcomp == 1, "R1", sts_txcomp, 1);
        chk(sts_txrdy == 1, "R1", sts_txrdy, 1);
        chk(sts_rxrdy == 0, "R1", sts_rxrdy, 0);
        chk(sts_nack == 0, "R1", sts_nack, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R1", {scl_oe, sda_oe}, 0);

        // Plain write of three bytes, auto stop (R2, R5, R6, R8, R11)
        cur_req = "R2"; s0 = starts; p0 = stops;
        wq = '{8'hA5, 8'h3C, 8'hFF};
        do_write(SLV, 0, 8'h00, 0);
        repeat (5) @(negedge clk);
        chk(exp_wr.size() == 0, "R6", exp_wr.size(), 0);
        chk(stops - p0 == 1, "R6", stops - p0, 1);
        chk(starts - s0 == 1, "R2", starts - s0, 1);
        chk(sts_txrdy == 1, "R5", sts_txrdy, 1);
        chk(sts_nack == 0, "R3", sts_nack, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R8", {scl_oe, sda_oe}, 0);
        chk(lo_last == LO, "R11", lo_last, LO);
        chk(hi_last == HI, "R11", hi_last, HI);

        // Register-index byte precedes data; extra start mid-transfer (R7, R12)
        cur_req = "R7"; s0 = starts;
        wq = '{8'h11, 8'h22};
        do_write(SLV, 1, 8'h3C, 1);
        repeat (5) @(negedge clk);
        chk(exp_wr.size() == 0, "R7", exp_wr.size(), 0);
        chk(starts - s0 == 1, "R12", starts - s0, 1);

        // Address-only write ends by itself (R6)
        cur_req = "R6"; p0 = stops;
        wq.delete();
        do_write(SLV, 0, 8'h00, 0);
        repeat (5) @(negedge clk);
        chk(exp_wr.size() == 0, "R6", exp_wr.size(), 0);
        chk(stops - p0 == 1, "R6", stops - p0, 1);

        // Three-byte read, stop requested before the last (R4, R9)
        cur_req = "R4"; a0 = macks; n0 = mnacks; p0 = stops;
        do_read(3);
        repeat (5) @(negedge clk);
        chk(macks - a0 == 2, "R4", macks - a0, 2);
        chk(mnacks - n0 == 1, "R9", mnacks - n0, 1);
        chk(stops - p0 == 1, "R9", stops - p0, 1);

        // One-byte read with start and stop together (R9)
        cur_req = "R9"; a0 = macks; n0 = mnacks;
        do_read(1);
        repeat (5) @(negedge clk);
        chk(macks - a0 == 0, "R9", macks - a0, 0);
        chk(mnacks - n0 == 1, "R9", mnacks - n0, 1);

        // Unknown address: flag held until status read (R3, R10)
        cur_req = "R3"; p0 = stops;
        wq.delete();
        do_write(7'h21, 0, 8'h00, 0);
        chk(sts_nack == 1, "R3", sts_nack, 1);
        chk(stops - p0 == 1, "R10", stops - p0, 1);
        repeat (10) @(negedge clk);
        chk(sts_nack == 1, "R3", sts_nack, 1);
        @(negedge clk); sts_rd = 1;
        @(negedge clk); sts_rd = 0;
        chk(sts_nack == 0, "R3", sts_nack, 0);

        // Data byte refused: transfer abandoned, held byte not sent (R10)
        cur_req = "R10"; nack_at = 2; p0 = stops;
        exp_wr.push_back({SLV, 1'b0}); exp_wr.push_back(8'h01); exp_wr.push_back(8'h02);
        cfg_read = 0; cfg_dev_addr = SLV; cfg_iaddr_en = 0;
        load_thr(8'h01);
        pulse_start(0);
        while (!sts_txrdy) @(negedge clk);
        load_thr(8'h02);
        while (!sts_txrdy) @(negedge clk);
        load_thr(8'h03);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(sts_nack == 1, "R10", sts_nack, 1);
        chk(exp_wr.size() == 0, "R10", exp_wr.size(), 0);
        chk(sts_txrdy == 0, "R10", sts_txrdy, 0);
        chk(stops - p0 == 1, "R10", stops - p0, 1);
        nack_at = -1;

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule